// File: doc/BRIEF.md
# Serial Byte-Pair Carry Adder

This block adds two unsigned operands of any length, one byte of each per clock, through an 8-bit adder and a single carry flag. It runs the same add-with-carry loop that a narrow processor uses to sum wide numbers. The operands arrive least significant byte first, as a stream of byte pairs with a valid/ready handshake and a flag on the final pair. Each accepted pair yields one result byte. The carry out of that addition is kept for the next pair.

When the flagged final pair has been added, the block sends one more byte that holds the remaining carry as 0x00 or 0x01. That byte carries the output last flag. An N-byte operand therefore gives an (N+1)-byte result. The carry is cleared once the extra byte is sent, so the next operation starts from a carry of zero. A stalled output holds its byte and blocks further input, so no byte is lost or repeated.

Top module: `sbadd_chain`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Each accepted input pair produces exactly one output byte equal to (in_a + in_b + carry_in) mod 256. Output bytes keep the order of the input pairs and have out_last = 0.
- R3: The carry into the first pair of every operation is zero.
- R4: The carry out of each pair's addition is the carry into the next pair of the same operation.
- R5: After the pair with in_last = 1, exactly one more byte is sent with out_last = 1. Its value is 0x01 if the final addition carried and 0x00 otherwise. An N-pair operation therefore yields N+1 bytes.
- R6: Once the final pair is accepted, no new pair is accepted until the extra carry byte has been placed on the output.
- R7: While out_valid = 1 and out_ready = 0, out_valid, out_data and out_last hold their values, and no byte is dropped or duplicated.
- R8: The carry is cleared after the extra byte, so an operation that ends with a carry has no effect on the next one.
- R9: A one-pair operation gives a two-byte result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte pair is present |
| in_ready | output | 1 | Block accepts the pair this cycle |
| in_a | input | 8 | Byte of operand A |
| in_b | input | 8 | Byte of operand B |
| in_last | input | 1 | This pair is the most significant pair of the operation |
| out_valid | output | 1 | Result byte is present |
| out_ready | input | 1 | Consumer takes the result byte this cycle |
| out_data | output | 8 | Result byte |
| out_last | output | 1 | This byte is the extra carry byte that ends the result |

## Verification
A wrong carry register shows up in the very next result byte of the same operation, or, if it is not cleared, in the first byte of the following operation. Long runs of 0xFF plus a single 0x01 bring such an error straight to the ports. A wrong sequencing state shows up in one of two ways: the result for an operation has the wrong length, or a new pair is accepted while the extra byte is still pending. A fault in the output register shows up within one stalled cycle, as a changed or repeated byte. Every cycle, the bench compares the output against a queue of expected bytes, so a fault is reported in the cycle it first reaches the output.

// File: rtl/sbadd_pkg.sv
`timescale 1ns/1ps
package sbadd_pkg;
  typedef enum logic {
    ST_ADD = 1'b0,
    ST_EXT = 1'b1
  } sbadd_state_e;
endpackage

// File: rtl/sbadd_rst_sync.sv
`timescale 1ns/1ps
module sbadd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sbadd_alu.sv
`timescale 1ns/1ps
module sbadd_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] cy;

  assign cy[0] = cin_i;

  generate
    for (genvar k = 0; k < W; k++) begin : g_bit
      assign sum_o[k]  = a_i[k] ^ b_i[k] ^ cy[k];
      assign cy[k+1]   = (a_i[k] & b_i[k]) | (cy[k] & (a_i[k] ^ b_i[k]));
    end
  endgenerate

  assign cout_o = cy[W];

  // R2: ripple chain agrees with arithmetic sum
  always_comb begin
    p_sum_ok_r2: assert ({cout_o, sum_o} ==
                         ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}));
  end
endmodule

// File: rtl/sbadd_ctrl.sv
`timescale 1ns/1ps
module sbadd_ctrl
  import sbadd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  input  logic slot_free,
  input  logic alu_cout,
  output logic in_ready,
  output logic load_sum,
  output logic load_ext,
  output logic carry_q
);
  sbadd_state_e state_q, state_d;
  logic         state_en;
  logic         carry_d, carry_en;

  always_comb begin
    in_ready = (state_q == ST_ADD) && slot_free;
    load_sum = in_valid && in_ready;
    load_ext = (state_q == ST_EXT) && slot_free;
  end

  always_comb begin
    state_d  = state_q;
    state_en = 1'b0;
    carry_d  = carry_q;
    carry_en = 1'b0;
    unique case (state_q)
      ST_ADD: begin
        if (load_sum) begin
          carry_d  = alu_cout;
          carry_en = 1'b1;
          if (in_last) begin
            state_d  = ST_EXT;
            state_en = 1'b1;
          end
        end
      end
      ST_EXT: begin
        if (load_ext) begin
          carry_d  = 1'b0;
          carry_en = 1'b1;
          state_d  = ST_ADD;
          state_en = 1'b1;
        end
      end
      default: begin
        state_d  = ST_ADD;
        state_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ADD;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
    end else if (carry_en) begin
      carry_q <= carry_d;
    end
  end

  // R6: after the final pair no further pair is taken next cycle
  p_block_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R8: carry is zero once the extra byte has been issued
  p_carry_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_ext |=> (carry_q == 1'b0));

  // R5: a final pair is always followed by an extra-byte load before new input
  p_ext_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sum && in_last) |=> !load_sum);
endmodule

// File: rtl/sbadd_outreg.sv
`timescale 1ns/1ps
module sbadd_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         load_last,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         slot_free
);
  logic         valid_d;
  logic         data_en;

  always_comb begin
    slot_free = !out_valid || out_ready;
    data_en   = load;
    if (load) begin
      valid_d = 1'b1;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end else begin
      valid_d = out_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_last <= 1'b0;
    end else if (data_en) begin
      out_data <= load_data;
      out_last <= load_last;
    end
  end

  // R7: a stalled byte stays put
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R5: the closing byte is only ever 0x00 or 0x01
  p_ext_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_data[W-1:1] == '0));
endmodule

// File: rtl/sbadd_chain.sv
`timescale 1ns/1ps
module sbadd_chain #(
  parameter int BYTE_W   = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_a,
  input  logic [BYTE_W-1:0] in_b,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  localparam int PAD_W = BYTE_W - 1;

  logic              srst_n;
  logic [BYTE_W-1:0] sum_w;
  logic              cout_w;
  logic              carry_q;
  logic              load_sum, load_ext, slot_free;
  logic [BYTE_W-1:0] load_data;

  sbadd_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sbadd_alu #(.W(BYTE_W)) u_alu (
    .a_i    (in_a),
    .b_i    (in_b),
    .cin_i  (carry_q),
    .sum_o  (sum_w),
    .cout_o (cout_w)
  );

  sbadd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .slot_free (slot_free),
    .alu_cout  (cout_w),
    .in_ready  (in_ready),
    .load_sum  (load_sum),
    .load_ext  (load_ext),
    .carry_q   (carry_q)
  );

  assign load_data = load_sum ? sum_w : {{PAD_W{1'b0}}, carry_q};

  sbadd_outreg #(.W(BYTE_W)) u_out (
    .clk       (clk),
    .rst_n     (srst_n),
    .load      (load_sum || load_ext),
    .load_data (load_data),
    .load_last (load_ext),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .slot_free (slot_free)
  );
endmodule

// File: tb/sbadd_chain_tb_top.sv
`timescale 1ns/1ps
module sbadd_chain_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic       last;
  } pair_t;

  typedef struct {
    logic [7:0] d;
    logic       l;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_last;
  logic [7:0] in_a, in_b;
  logic       out_valid, out_ready, out_last;
  logic [7:0] out_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  int  bp_mode = 0;
  int  gap_mode = 0;
  logic [31:0] seed = 32'h1234_5678;

  pair_t src_q[$];
  exp_t  exp_q[$];
  int    len_q[$];
  int    mc = 0;
  int    cur_len = 0;
  int    out_cnt = 0;
  bit    prev_carry = 1'b0;
  bit    hold_prev = 1'b0;
  logic [7:0] hold_data;
  logic       hold_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbadd_chain dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
    end
  endtask

  task automatic add_op(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      pair_t p;
      logic [31:0] r = rnd();
      case (mode)
        1: begin p.a = 8'hFF; p.b = (i == 0) ? 8'h01 : 8'h00; end
        2: begin p.a = 8'hFF; p.b = 8'hFF; end
        3: begin p.a = 8'h00; p.b = 8'h00; end
        default: begin p.a = r[23:16]; p.b = r[15:8]; end
      endcase
      p.last = (i == n - 1);
      src_q.push_back(p);
    end
  endtask

  task automatic step();
    bit in_fire, out_fire;
    logic [31:0] r;
    @(negedge clk);
    r = rnd();
    in_valid  = (src_q.size() > 0) && !(gap_mode != 0 && r[18:17] == 2'b00);
    if (src_q.size() > 0) begin
      in_a = src_q[0].a; in_b = src_q[0].b; in_last = src_q[0].last;
    end else begin
      in_a = r[7:0]; in_b = r[15:8]; in_last = 1'b0;
    end
    case (bp_mode)
      1: out_ready = r[21];
      2: out_ready = (r[25:24] == 2'b11);
      default: out_ready = 1'b1;
    endcase
    #1;
    // R7: stalled byte must still be presented unchanged
    if (hold_prev) begin
      chk(out_valid == 1'b1, "R7", "valid held", out_valid, 1);
      chk(out_data == hold_data && out_last == hold_last, "R7", "data held",
          {out_last, out_data}, {hold_last, hold_data});
    end
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected byte", out_data, 0);
      end else begin
        chk(out_data == exp_q[0].d, exp_q[0].tag, "data", out_data, exp_q[0].d);
        chk(out_last == exp_q[0].l, exp_q[0].tag, "last", out_last, exp_q[0].l);
      end
    end
    in_fire  = in_valid && in_ready;
    out_fire = out_valid && out_ready;
    hold_prev = out_valid && !out_ready;
    hold_data = out_data;
    hold_last = out_last;
    if (out_fire && exp_q.size() > 0) begin
      exp_t e = exp_q.pop_front();
      out_cnt++;
      if (e.l) begin
        int n = (len_q.size() > 0) ? len_q.pop_front() : -1;
        chk(out_cnt == n + 1, (n == 1) ? "R9" : "R5", "result length", out_cnt, n + 1);
        out_cnt = 0;
      end
    end
    if (in_fire) begin
      pair_t p = src_q.pop_front();
      int s;
      exp_t e;
      bit early = 1'b0;
      // R6: no pair accepted while an extra byte is still queued behind the output
      for (int k = 1; k < exp_q.size(); k++) if (exp_q[k].l) early = 1'b1;
      chk(!early, "R6", "pair accepted before extra byte", early, 0);
      s = int'(p.a) + int'(p.b) + mc;
      e.d = s[7:0];
      e.l = 1'b0;
      e.tag = (cur_len == 0) ? (prev_carry ? "R8" : "R3") : ((mc != 0) ? "R4" : "R2");
      exp_q.push_back(e);
      cur_len++;
      mc = s >> 8;
      if (p.last) begin
        exp_t x;
        x.d = mc[7:0];
        x.l = 1'b1;
        x.tag = "R5";
        exp_q.push_back(x);
        len_q.push_back(cur_len);
        prev_carry = (mc != 0);
        mc = 0;
        cur_len = 0;
      end
    end
  endtask

  task automatic run_all();
    int guard = 0;
    while ((src_q.size() > 0 || exp_q.size() > 0) && guard < 5000) begin
      step();
      guard++;
    end
    chk(exp_q.size() == 0, "R2", "drain complete", exp_q.size(), 0);
  endtask

  initial begin
    in_valid = 1'b0; in_a = '0; in_b = '0; in_last = 1'b0; out_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // directed: single pair with carry (R9), carry chain (R4), clean start after carry (R8)
    bp_mode = 0; gap_mode = 0;
    add_op(1, 2);
    add_op(4, 1);
    add_op(3, 3);
    add_op(1, 3);
    add_op(6, 2);
    for (int i = 0; i < 10; i++) add_op(1 + int'(rnd() % 8), 0);
    run_all();

    // backpressure and input gaps (R7)
    bp_mode = 1; gap_mode = 1;
    for (int i = 0; i < 20; i++) add_op(1 + int'(rnd() % 8), int'(rnd() % 4));
    run_all();

    // heavy backpressure
    bp_mode = 2; gap_mode = 0;
    add_op(1, 2);
    add_op(1, 0);
    add_op(5, 1);
    for (int i = 0; i < 10; i++) add_op(1 + int'(rnd() % 8), 0);
    run_all();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", WD_CYCLES, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule